// File: doc/BRIEF.md
# Double-Buffered Quad Converter Register Bank

This block is the digital front end of a four-channel, 12-bit converter. A host reaches it through a chip-select, read/write strobe, 2-bit channel address and a 12-bit data bus. The bus is split into `data_in`, `data_out` and `data_oe`. Each channel has two register stages. The first stage is a staging register, written by the host, and the host can read it back. The second stage holds the code that the channel exports. A shared active-low load strobe moves all four staged words into the exported stage together.

Level-transparent behaviour is modelled with registers clocked in one domain. A register that is "open" captures its source on every clock edge while its enable condition holds. A synchronous reset drives all eight registers to one code, chosen by parameter as mid-scale or zero. Registers that are closed when reset is released keep that code. If the load strobe is tied low, a host write reaches the exported code on the same edge that stores it, with no added latency.

Top module: `qdac_regbank`

## Requirements
- R1: While `cs_n`=0 and `rw`=0 (rw=0 means write), the addressed staging register takes `data_in` on each rising clock edge, bit for bit (bit 0 is the LSB, straight binary).
- R2: The channel index is `addr` read as an unsigned number: 0=A, 1=B, 2=C, 3=D. `addr[1]` high selects C or D, and `addr[0]` high selects B or D. Channel i's exported code is `dac_code[12*i+11 : 12*i]`.
- R3: A write changes only the addressed staging register. The other three keep their values.
- R4: While `cs_n`=0 and `rw`=1, the addressed staging register is read. In the cycle after each such edge, `data_oe`=1 and `data_out` equals that register's content at the sampling edge.
- R5: `data_oe` is 0 in the cycle after any edge with no read access, and in the cycle after any edge with `rst` high.
- R6: On every edge where `ld_n`=0, each exported register takes the value its staging register holds after that same edge.
- R7: On every edge where `ld_n`=1 (and `rst`=0), the exported codes do not change.
- R8: With `ld_n` held at 0, a write appears on its channel's exported code in the cycle right after the write edge.
- R9: On an edge with `rst`=1, all staging and exported registers become the reset code, whatever the values of `cs_n`, `rw`, `addr` and `ld_n`.
- R10: After `rst` falls, registers that are not opened keep the reset code. This holds for the exported codes while `ld_n`=1, and for the staging registers until they are written.
- R11: Parameter `MIDSCALE`=1 selects reset code 12'h800, and `MIDSCALE`=0 selects 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the reset code |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = readback, 0 = write |
| addr | input | 2 | Channel address |
| ld_n | input | 1 | Active-low load of all exported registers |
| data_in | input | 12 | Write data |
| data_out | output | 12 | Readback data |
| data_oe | output | 1 | Readback bus drive enable |
| dac_code | output | 48 | Four exported codes, channel A in the low bits |

## Verification
Two functions can fall on one edge. The first case is a staging write together with an open load strobe. The bench holds `ld_n` low while writing and checks the exported code one cycle later, with no extra cycle of delay. The second case is reset together with a write, a read and an open load strobe. The bench keeps all strobes active during reset and checks that every code equals the reset value and that `data_oe` stays low.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } bus_dir_e;

  function automatic logic [31:0] reset_word(input int width, input bit mid);
    logic [31:0] w;
    w = '0;
    if (mid) w[width-1] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/qdac_sel.sv
module qdac_sel
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rw,
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] wr_en,
  output logic           rd_en
);

  logic access;
  assign access = !rst && !cs_n;
  assign rd_en  = access && (rw == DIR_READ);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign wr_en[i] = access && (rw == DIR_WRITE) && (addr == AW'(i));
  end

  p_single_open_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  p_no_write_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (wr_en == '0));

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int             DW       = 12,
  parameter logic [DW-1:0]  RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          ld_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] code_q
);

  logic [DW-1:0] stage_nxt;
  assign stage_nxt = wr_en ? din : stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= RST_CODE;
      code_q  <= RST_CODE;
    end else begin
      stage_q <= stage_nxt;
      if (!ld_n) code_q <= stage_nxt;
    end
  end

  p_write_capture_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (stage_q == $past(din)));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(stage_q));
  p_load_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (code_q == stage_q));
  p_load_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(code_q));

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_code_r9: assert (stage_q == RST_CODE && code_q == RST_CODE);
    end
  end

endmodule

// File: rtl/qdac_rdback.sv
module qdac_rdback #(
  parameter int DW  = 12,
  parameter int NCH = 4,
  parameter int AW  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [NCH-1:0][DW-1:0]  stage,
  output logic [DW-1:0]           data_out,
  output logic                    data_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe <= rd_en;
      if (rd_en) data_out <= stage[addr];
    end
  end

  p_readback_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (data_oe && data_out == $past(stage[addr])));
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !data_oe);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      p_oe_reset_r5: assert (!data_oe);
    end
  end

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int DW       = 12,
  parameter int NCH      = 4,
  parameter bit MIDSCALE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n,
  input  logic                          rw,
  input  logic [$clog2(NCH)-1:0]        addr,
  input  logic                          ld_n,
  input  logic [DW-1:0]                 data_in,
  output logic [DW-1:0]                 data_out,
  output logic                          data_oe,
  output logic [NCH*DW-1:0]             dac_code
);

  localparam int            AW       = $clog2(NCH);
  localparam logic [31:0]   RST_WORD = reset_word(DW, MIDSCALE);
  localparam logic [DW-1:0] RST_CODE = RST_WORD[DW-1:0];

  logic [NCH-1:0]         wr_en;
  logic                   rd_en;
  logic [NCH-1:0][DW-1:0] stage;
  logic [NCH-1:0][DW-1:0] code;

  qdac_sel #(.NCH(NCH), .AW(AW)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .rw    (rw),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdac_chan #(.DW(DW), .RST_CODE(RST_CODE)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[i]),
      .ld_n    (ld_n),
      .din     (data_in),
      .stage_q (stage[i]),
      .code_q  (code[i])
    );
    assign dac_code[i*DW +: DW] = code[i];
  end

  qdac_rdback #(.DW(DW), .NCH(NCH), .AW(AW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .stage    (stage),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

  p_pass_through_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && !cs_n && rw == DIR_WRITE) |=> (code[$past(addr)] == $past(data_in)));

endmodule

// File: tb/tb_qdac_regbank.sv
module tb_qdac_regbank;

  localparam int DW = 12;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic rw = 1'b1;
  logic [1:0] addr = '0;
  logic ld_n = 1'b1;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out, data_out_z;
  logic data_oe, data_oe_z;
  logic [NCH*DW-1:0] dac_code, dac_code_z;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  qdac_regbank #(.DW(DW), .NCH(NCH), .MIDSCALE(1'b1)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .ld_n(ld_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .dac_code(dac_code));

  qdac_regbank #(.DW(DW), .NCH(NCH), .MIDSCALE(1'b0)) dut_z (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .ld_n(ld_n),
    .data_in(data_in), .data_out(data_out_z), .data_oe(data_oe_z), .dac_code(dac_code_z));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] code_of(input logic [NCH*DW-1:0] v, input int ch);
    return v[ch*DW +: DW];
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
    cs_n = 1'b0; rw = 1'b0; addr = a; data_in = d;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic check_read(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
    cs_n = 1'b0; rw = 1'b1; addr = a;
    @(negedge clk);
    cs_n = 1'b1;
    check(req, {{(DW-1){1'b0}}, data_oe}, 1);
    check(req, data_out, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; cs_n = 1'b0; rw = 1'b0; ld_n = 1'b0; addr = 2'd2; data_in = 12'h5A5;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      check("R9 mid code", code_of(dac_code, i), 12'h800);
      check("R11 zero code", code_of(dac_code_z, i), 12'h000);
    end
    check("R5 oe in reset", {{(DW-1){1'b0}}, data_oe}, 0);
    cs_n = 1'b1; rw = 1'b1; ld_n = 1'b1;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_persist();
    repeat (2) @(negedge clk);
    for (int i = 0; i < NCH; i++) check("R10 code kept", code_of(dac_code, i), 12'h800);
    check_read("R10 stage kept", 2'd3, 12'h800);
    check("R10 zero kept", code_of(dac_code_z, 1), 12'h000);
  endtask

  task automatic t_write_map();
    do_write(2'd0, 12'h001);
    check_read("R3 B untouched", 2'd1, 12'h800);
    do_write(2'd1, 12'h123);
    do_write(2'd2, 12'hABC);
    do_write(2'd3, 12'h800 ^ 12'hFFF);
    check_read("R1 A lsb", 2'd0, 12'h001);
    check_read("R2 B", 2'd1, 12'h123);
    check_read("R2 C", 2'd2, 12'hABC);
    check_read("R4 D", 2'd3, 12'h7FF);
    check("R7 code held", code_of(dac_code, 2), 12'h800);
  endtask

  task automatic t_oe_idle();
    cs_n = 1'b1; rw = 1'b1;
    @(negedge clk);
    check("R5 oe idle", {{(DW-1){1'b0}}, data_oe}, 0);
    cs_n = 1'b0; rw = 1'b0; addr = 2'd1; data_in = 12'h321;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
    check("R5 oe on write", {{(DW-1){1'b0}}, data_oe}, 0);
    do_write(2'd1, 12'h123);
  endtask

  task automatic t_load();
    ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1;
    check("R6 A", code_of(dac_code, 0), 12'h001);
    check("R6 B", code_of(dac_code, 1), 12'h123);
    check("R6 C", code_of(dac_code, 2), 12'hABC);
    check("R6 D", code_of(dac_code, 3), 12'h7FF);
    do_write(2'd1, 12'hFFF);
    @(negedge clk);
    check("R7 B held", code_of(dac_code, 1), 12'h123);
    check_read("R7 stage B", 2'd1, 12'hFFF);
  endtask

  task automatic t_pass();
    ld_n = 1'b0;
    do_write(2'd2, 12'h3C3);
    check("R8 C pass", code_of(dac_code, 2), 12'h3C3);
    check("R8 B loaded", code_of(dac_code, 1), 12'hFFF);
    do_write(2'd3, 12'h000);
    check("R8 D pass", code_of(dac_code, 3), 12'h000);
    check("R8 A kept", code_of(dac_code, 0), 12'h001);
    ld_n = 1'b1;
  endtask

  task automatic t_reset_again();
    rst = 1'b1; cs_n = 1'b0; rw = 1'b1; addr = 2'd0;
    @(negedge clk);
    rst = 1'b0; cs_n = 1'b1;
    check("R9 reset over read", {{(DW-1){1'b0}}, data_oe}, 0);
    check("R9 A", code_of(dac_code, 0), 12'h800);
    check("R9 D", code_of(dac_code, 3), 12'h800);
    check_read("R9 stage C", 2'd2, 12'h800);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_persist();
    t_write_map();
    t_oe_idle();
    t_load();
    t_pass();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule